// File: doc/BRIEF.md
# Configuration-Programmed I/O Window Decoder

This block holds the base-address and enable settings of two I/O windows inside a PCI-style configuration space, and decides for each I/O access whether it falls into either window. The first window covers a 64-byte power management register block. The second covers a 64-byte system-management-bus controller block. Software places and opens each window by writing configuration dwords through a simple write/read port with byte enables. The I/O side presents an address with a strobe and gets back a hit flag and the offset within the window for each window.

Both windows are naturally aligned to 64 bytes, so decode uses only address bits 15:6 of the programmed base. Bit 0 of each base dword is a fixed indicator that always reads 1. The power management window comes out of reset closed. The bus controller window comes out of reset open at a base given by a parameter.

Top module: `iowin_decode_top`

## Requirements
- R1: After reset, dword 0x40 reads 0x00000001 and byte 0x80 reads 0. Dword 0x90 reads {16'h0, SMB_BASE_INIT with bit 0 set}, and byte 0xD2 reads 0x09. Configuration dwords are addressed by cfg_dword_addr = byte offset / 4, so byte 0xD2 appears in bits 23:16 of dword 0x34.
- R2: A write to dword 0x40 or dword 0x90 loads every byte lane whose cfg_be bit is set and leaves the other lanes unchanged. Bit 0 of bytes 0x40 and 0x90 ignores writes and always reads 1.
- R3: A write to byte 0x80 (lane 0 of dword 0x20) or byte 0xD2 (lane 2 of dword 0x34) loads that whole byte. The window is open exactly when bit 0 of its enable byte is 1.
- R4: pm_hit is 1 when io_strobe is 1, the power management window is open, and io_addr[15:6] equals bits 15:6 of dword 0x40. smb_hit follows the same rule with dword 0x90 and byte 0xD2. Each offset output is io_addr[5:0] while its hit is 1, and 0 otherwise.
- R5: hit and offset are combinational from io_addr and io_strobe. A configuration write takes effect on decode from the cycle after the write cycle, and an access in the write cycle itself still uses the old settings.
- R6: No configuration state changes in these cases: cfg_wr is 0, a byte lane is not enabled, the write targets a dword other than 0x10, 0x20, 0x24 or 0x34, or the write targets a byte of dword 0x20 or 0x34 other than the enable byte.
- R7: Readback is combinational from cfg_dword_addr. Unmapped dwords, and the bytes of dwords 0x20 and 0x34 other than the enable byte, read 0.
- R8: The two windows decode independently. When both are programmed to the same range and both are open, pm_hit and smb_hit are both 1.
- R9: Base bits 5:1 and 31:16 are stored and read back but play no part in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dword_addr | input | 6 | Configuration dword index (byte offset / 4) for write and readback |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback of the addressed dword |
| io_strobe | input | 1 | I/O access valid |
| io_addr | input | 16 | I/O access address |
| pm_hit | output | 1 | Access falls in the power management window |
| pm_offset | output | 6 | Offset within the power management window |
| smb_hit | output | 1 | Access falls in the bus controller window |
| smb_offset | output | 6 | Offset within the bus controller window |

## Verification
Readback and decode are combinational from the current inputs, so they are due in the same cycle as the stimulus. A configuration write is due on the decode and readback outputs in the cycle after the edge that captures it. The bench drives each stimulus just after a rising edge and compares every output at the following falling edge against a byte-array model. The model is updated only on rising edges, so the cycle in which a write is applied is checked against the old settings and the next cycle against the new ones. Windows are probed one byte below their base, at the first and last byte, and one byte past the end.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  localparam int CFG_DW_W  = 6;
  localparam int IO_AW     = 16;
  localparam int WIN_SHIFT = 6;
  localparam int NUM_WIN   = 2;
  localparam int LANES     = 4;

  typedef struct packed {
    logic [CFG_DW_W-1:0] base_dw;
    logic [CFG_DW_W-1:0] en_dw;
    logic [1:0]          en_lane;
    logic [31:0]         base_rst;
    logic [7:0]          en_rst;
  } win_cfg_t;

  // Window 0: power management, window 1: bus controller
  function automatic win_cfg_t win_layout(int idx, logic [IO_AW-1:0] smb_init);
    win_cfg_t c;
    if (idx == 0) begin
      c.base_dw  = 6'h10;
      c.en_dw    = 6'h20;
      c.en_lane  = 2'd0;
      c.base_rst = 32'h0000_0001;
      c.en_rst   = 8'h00;
    end else begin
      c.base_dw  = 6'h24;
      c.en_dw    = 6'h34;
      c.en_lane  = 2'd2;
      c.base_rst = {16'h0, smb_init[15:1], 1'b1};
      c.en_rst   = 8'h09;
    end
    return c;
  endfunction

  function automatic logic in_window(logic [IO_AW-1:0] addr,
                                     logic [IO_AW-1:WIN_SHIFT] base_hi);
    return addr[IO_AW-1:WIN_SHIFT] == base_hi;
  endfunction
endpackage

// File: rtl/iowin_match.sv
module iowin_match
  import iowin_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [IO_AW-1:WIN_SHIFT]  base_hi,
  input  logic                      open,
  input  logic                      io_strobe,
  input  logic [IO_AW-1:0]          io_addr,
  output logic                      hit,
  output logic [WIN_SHIFT-1:0]      offset
);
  logic addr_in_range;

  assign addr_in_range = in_window(io_addr, base_hi);
  assign hit    = io_strobe & open & addr_in_range;
  assign offset = hit ? io_addr[WIN_SHIFT-1:0] : '0;

  // R4: an offset is only presented together with a hit
  a_r4_offset_quiet_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> offset == '0);
endmodule

// File: rtl/iowin_window.sv
module iowin_window
  import iowin_pkg::*;
#(
  parameter logic [CFG_DW_W-1:0] BASE_DW  = 6'h10,
  parameter logic [CFG_DW_W-1:0] EN_DW    = 6'h20,
  parameter int                  EN_LANE  = 0,
  parameter logic [31:0]         BASE_RST = 32'h1,
  parameter logic [7:0]          EN_RST   = 8'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_DW_W-1:0]  cfg_dword_addr,
  input  logic [LANES-1:0]     cfg_be,
  input  logic [31:0]          cfg_wdata,
  input  logic                 io_strobe,
  input  logic [IO_AW-1:0]     io_addr,
  output logic [31:0]          base_q,
  output logic [7:0]           en_q,
  output logic                 hit,
  output logic [WIN_SHIFT-1:0] offset
);
  logic base_upd;
  logic en_upd;

  assign base_upd = cfg_wr && (cfg_dword_addr == BASE_DW) && (|cfg_be);
  assign en_upd   = cfg_wr && (cfg_dword_addr == EN_DW) && cfg_be[EN_LANE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RST;
    end else if (base_upd) begin
      for (int l = 0; l < LANES; l++) begin
        if (cfg_be[l]) base_q[8*l +: 8] <= cfg_wdata[8*l +: 8];
      end
      base_q[0] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= EN_RST;
    else if (en_upd) en_q <= cfg_wdata[8*EN_LANE +: 8];
  end

  iowin_match u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_hi   (base_q[IO_AW-1:WIN_SHIFT]),
    .open      (en_q[0]),
    .io_strobe (io_strobe),
    .io_addr   (io_addr),
    .hit       (hit),
    .offset    (offset)
  );

  // R6: base holds when no write reaches its dword
  a_r6_base_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !base_upd |=> $stable(base_q));
  // R6: enable holds when its byte is not written
  a_r6_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !en_upd |=> $stable(en_q));
  // R3: enable byte takes the written lane
  a_r3_enable_loads: assert property (@(posedge clk) disable iff (!rst_n)
    en_upd |=> en_q == $past(cfg_wdata[8*EN_LANE +: 8]));
  // R2: written high lane of the base takes the data
  a_r2_base_lane1_loads: assert property (@(posedge clk) disable iff (!rst_n)
    base_upd && cfg_be[1] |=> base_q[15:8] == $past(cfg_wdata[15:8]));
  // R2: indicator bit survives every write
  a_r2_indicator_set: assert property (@(posedge clk) disable iff (!rst_n)
    base_upd |=> base_q[0]);
endmodule

// File: rtl/iowin_decode_top.sv
module iowin_decode_top
  import iowin_pkg::*;
#(
  parameter logic [15:0] SMB_BASE_INIT = 16'h1100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [5:0]  cfg_dword_addr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        io_strobe,
  input  logic [15:0] io_addr,
  output logic        pm_hit,
  output logic [5:0]  pm_offset,
  output logic        smb_hit,
  output logic [5:0]  smb_offset
);
  logic [31:0]          base_v [NUM_WIN];
  logic [7:0]           en_v   [NUM_WIN];
  logic                 hit_v  [NUM_WIN];
  logic [WIN_SHIFT-1:0] off_v  [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam win_cfg_t C = win_layout(w, SMB_BASE_INIT);
    iowin_window #(
      .BASE_DW  (C.base_dw),
      .EN_DW    (C.en_dw),
      .EN_LANE  (int'(C.en_lane)),
      .BASE_RST (C.base_rst),
      .EN_RST   (C.en_rst)
    ) u_win (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_wr         (cfg_wr),
      .cfg_dword_addr (cfg_dword_addr),
      .cfg_be         (cfg_be),
      .cfg_wdata      (cfg_wdata),
      .io_strobe      (io_strobe),
      .io_addr        (io_addr),
      .base_q         (base_v[w]),
      .en_q           (en_v[w]),
      .hit            (hit_v[w]),
      .offset         (off_v[w])
    );
  end

  // Readback: OR of every window's mapped dwords
  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (cfg_dword_addr == win_layout(w, SMB_BASE_INIT).base_dw)
        cfg_rdata = cfg_rdata | base_v[w];
      if (cfg_dword_addr == win_layout(w, SMB_BASE_INIT).en_dw)
        cfg_rdata = cfg_rdata |
                    (32'(en_v[w]) << (8 * win_layout(w, SMB_BASE_INIT).en_lane));
    end
  end

  assign pm_hit     = hit_v[0];
  assign pm_offset  = off_v[0];
  assign smb_hit    = hit_v[1];
  assign smb_offset = off_v[1];

  // R4: no hit without an access
  a_r4_hit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_hit || smb_hit) |-> io_strobe);
  // R2: both base dwords always show the indicator bit
  a_r2_readback_indicator: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dword_addr == 6'h10 || cfg_dword_addr == 6'h24) |-> cfg_rdata[0]);
  // R7: dwords outside the map read zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_dword_addr inside {6'h10, 6'h20, 6'h24, 6'h34}) |-> cfg_rdata == '0);
endmodule

// File: tb/iowin_decode_top_bench.sv
module iowin_decode_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dword_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        io_strobe = 1'b0;
  logic [15:0] io_addr = '0;
  logic        pm_hit, smb_hit;
  logic [5:0]  pm_offset, smb_offset;

  int checks = 0;
  int failures = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;
  string cur_req = "R1";
  logic [7:0] mcfg [0:255];

  always #10 clk = ~clk;

  iowin_decode_top u_iowin_decode_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dword_addr(cfg_dword_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_strobe(io_strobe), .io_addr(io_addr), .pm_hit(pm_hit),
    .pm_offset(pm_offset), .smb_hit(smb_hit), .smb_offset(smb_offset)
  );

  function automatic bit writable(int a);
    return (a >= 'h40 && a <= 'h43) || a == 'h80 ||
           (a >= 'h90 && a <= 'h93) || a == 'hD2;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) mcfg[i] = 8'h00;
    mcfg['h40] = 8'h01;
    mcfg['h90] = 8'h01;
    mcfg['h91] = 8'h11;
    mcfg['hD2] = 8'h09;
  endtask

  // Reference model: byte-addressed configuration space
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else if (cfg_wr) begin
      for (int l = 0; l < 4; l++) begin
        int a;
        a = cfg_dword_addr * 4 + l;
        if (cfg_be[l] && writable(a)) mcfg[a] = cfg_wdata[8*l +: 8];
      end
      mcfg['h40][0] = 1'b1;
      mcfg['h90][0] = 1'b1;
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_decode(int base_lo, int en_byte);
    logic [15:0] b;
    logic h;
    b = {mcfg[base_lo + 1], mcfg[base_lo]};
    h = io_strobe && mcfg[en_byte][0] && (io_addr[15:6] == b[15:6]);
    return {h, h ? io_addr[5:0] : 6'd0};
  endfunction

  always @(negedge clk) begin
    if (checking) begin
      int a;
      a = cfg_dword_addr * 4;
      check("readback", cfg_rdata, {mcfg[a+3], mcfg[a+2], mcfg[a+1], mcfg[a]});
      check("pm decode", {25'd0, pm_hit, pm_offset}, {25'd0, exp_decode('h40, 'h80)});
      check("smb decode", {25'd0, smb_hit, smb_offset}, {25'd0, exp_decode('h90, 'hD2)});
    end
  end

  task automatic drive(bit wr, int dw, logic [3:0] be, logic [31:0] wd,
                       bit stb, logic [15:0] ad);
    @(posedge clk);
    #1;
    cfg_wr = wr; cfg_dword_addr = 6'(dw); cfg_be = be; cfg_wdata = wd;
    io_strobe = stb; io_addr = ad;
  endtask

  task automatic probe(logic [15:0] base);
    drive(0, 'h10, 0, 0, 1, base - 16'd1);
    drive(0, 'h20, 0, 0, 1, base);
    drive(0, 'h24, 0, 0, 1, base + 16'd63);
    drive(0, 'h34, 0, 0, 1, base + 16'd64);
    drive(0, 'h10, 0, 0, 0, base);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    checking = 1'b1;
    // R1: reset contents and open bus controller window
    cur_req = "R1";
    drive(0, 'h10, 0, 0, 1, 16'h0000);
    drive(0, 'h20, 0, 0, 1, 16'h1100);
    drive(0, 'h24, 0, 0, 0, 16'h0000);
    drive(0, 'h34, 0, 0, 0, 16'h0000);
    probe(16'h1100);
    // R2 and R9: base write with low bits and upper lanes set
    cur_req = "R2";
    drive(1, 'h10, 4'b1111, 32'hA5A5_C07E, 0, 0);
    drive(0, 'h10, 0, 0, 0, 0);
    cur_req = "R9";
    probe(16'hC040);
    // R5: enable write and access in the same cycle use old settings
    cur_req = "R5";
    drive(1, 'h20, 4'b0001, 32'h0000_00FF, 1, 16'hC045);
    drive(0, 'h20, 0, 0, 1, 16'hC045);
    // R3 and R4: open window sweep
    cur_req = "R4";
    probe(16'hC040);
    for (int i = 0; i < 64; i += 7) drive(0, 'h20, 0, 0, 1, 16'hC040 + 16'(i));
    // R6: ignored writes
    cur_req = "R6";
    drive(1, 'h20, 4'b1110, 32'h0, 1, 16'hC040);
    drive(1, 'h34, 4'b1011, 32'h0, 1, 16'h1100);
    drive(0, 'h20, 4'b0001, 32'h0, 1, 16'hC040);
    drive(1, 'h11, 4'b1111, 32'hFFFF_FFFF, 1, 16'hC040);
    drive(1, 'h10, 4'b0000, 32'h0, 1, 16'hC040);
    drive(0, 'h11, 0, 0, 1, 16'h1100);
    drive(0, 'h34, 0, 0, 1, 16'hC040);
    // R2: single-lane update of bus controller base high byte
    cur_req = "R2";
    drive(1, 'h24, 4'b0010, 32'h0000_2200, 1, 16'h1100);
    drive(0, 'h24, 0, 0, 1, 16'h2200);
    probe(16'h2200);
    // R3: close the power management window
    cur_req = "R3";
    drive(1, 'h20, 4'b0001, 32'h0000_00FE, 1, 16'hC040);
    drive(0, 'h20, 0, 0, 1, 16'hC040);
    drive(1, 'h20, 4'b0001, 32'h0000_0001, 0, 0);
    // R8: both windows on the same range
    cur_req = "R8";
    drive(1, 'h24, 4'b0011, 32'h0000_C040, 0, 0);
    probe(16'hC040);
    drive(1, 'h34, 4'b0100, 32'h0000_0000, 1, 16'hC050);
    drive(0, 'h34, 0, 0, 1, 16'hC050);
    // R7: unmapped readback
    cur_req = "R7";
    drive(0, 'h00, 0, 0, 0, 0);
    drive(0, 'h3F, 0, 0, 0, 0);
    drive(0, 'h21, 0, 0, 0, 0);
    @(negedge clk);
    checking = 1'b0;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule